// File: doc/BRIEF.md
# Shadow-Buffered Clock Register Access Controller

This block is the register-side logic of a real-time clock that sits behind a two-wire serial bus. A bit-level front end reduces bus activity to one-cycle event strobes: a start, every byte received from the master, the acknowledge clock of each byte, a request for the next read byte, a valid stop and an abort. The block decodes the device-select and address bytes. It keeps a running address pointer and serves three register groups: a two-byte control group at 0x00-0x01, an eight-byte time group at 0x02-0x09 and a one-byte status register at 0x0A.

The time group is a 64-bit seconds counter. It advances on every one-second tick and is stored little-endian, with the least significant byte at 0x02. Time writes never touch the counter directly. On the write's first acknowledge, the current count is copied into a staging buffer, and incoming bytes replace only their own positions. On a valid stop, the staged image is armed, and it is loaded at the next tick. Reads return bytes from a snapshot taken at the acknowledge that precedes read data. Sequential transfers wrap inside the group they start in.

Top module: `rtcr_top`

## Requirements
- R1: Only a device-select byte whose upper seven bits are 1101111 is acknowledged. Bit 0 set means read and clear means write. Any other select byte gets no acknowledge (ack_o low), and the bytes that follow are ignored until the next start.
- R2: In a write, the byte after the device-select is the address. Values 0x00-0x3F are acknowledged and load the pointer. Values of 0x40 and above are not acknowledged and end the transfer.
- R3: In a write, the acknowledge strobe after the address byte copies the counter into the staging buffer. After a valid stop, the next tick loads the counter with the staged image. The tick after that increments from the loaded value.
- R4: An abort, or a repeated start, discards staged time data, and the counter is left to keep counting.
- R5: The counter increments by one on every tick and does not change without one, including while a write is open.
- R6: Writing one time byte replaces only that byte. The other seven bytes take the values copied at the write's first acknowledge.
- R7: In a read, the acknowledge strobe after the device-select snapshots the counter. Ticks after that point do not alter the time bytes returned.
- R8: After each byte, the pointer steps forward inside the group where the transfer began: 0x01 wraps to 0x00, 0x09 wraps to 0x02, and 0x0A stays at 0x0A. Addresses 0x0B-0x3F step by one, read as 0x00 and ignore writes.
- R9: Only one status byte is allowed per transfer. A second data byte is not acknowledged and halts the transfer (halt_o high). A second read request halts the transfer and leaves tx_data_o unchanged. The halt lasts until the next stop, start or abort.
- R10: Control and time writes take effect only while status bit 1 and bit 2 are both set. Otherwise they are acknowledged and ignored. A status write needs no enable and takes effect at once.
- R11: The pointer persists between transfers. A current-address read, which is a read-select with no address byte, continues from the address after the last byte accessed, with the R8 wrap applied.
- R12: After reset, all registers and the counter are zero, and ack_o, halt_o and tx_data_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-second tick strobe |
| start_i | input | 1 | Start or repeated-start strobe |
| stop_i | input | 1 | Valid stop strobe |
| abort_i | input | 1 | Invalid-transfer strobe |
| byte_vld_i | input | 1 | A byte from the master is present |
| byte_i | input | 8 | Received byte |
| ack_i | input | 1 | Acknowledge-clock strobe |
| rd_req_i | input | 1 | Request for the next read byte |
| ack_o | output | 1 | Acknowledge decision for the last received byte |
| halt_o | output | 1 | Transfer halted by a status overrun |
| tx_data_o | output | 8 | Read byte, valid the cycle after rd_req_i |
| time_o | output | 64 | Running seconds counter |

## Verification
The embedded properties run on every cycle. They check that the counter moves only on a tick and, when a commit is pending, lands on the armed image. They also check that the read snapshot moves only on its strobe, that an abort never arms a commit, that the pointer stays inside its group, that a halt is sticky, and that control bytes are frozen while the enables are clear. Other behaviours need whole transfers to show. These are the byte merge of the staging buffer, the one-tick delay of a commit, the rejection of select and address bytes, the wrap order of sequential reads from every start address, and pointer carry-over into a current-address read. The bench's scenarios cover these.

// File: rtl/rtcr_pkg.sv
`timescale 1ns/1ps
package rtcr_pkg;
    localparam int AW      = 6;
    localparam int BW      = 8;
    localparam int CTRL_LO = 0;
    localparam int CTRL_N  = 2;
    localparam int CTRL_HI = CTRL_LO + CTRL_N - 1;
    localparam int CIW     = $clog2(CTRL_N);
    localparam int TIME_LO = CTRL_HI + 1;
    localparam int TIME_N  = 8;
    localparam int TIME_HI = TIME_LO + TIME_N - 1;
    localparam int TIX_W   = $clog2(TIME_N);
    localparam int TW      = TIME_N * BW;
    localparam int STAT_AD = TIME_HI + 1;
    localparam logic [6:0] DEV_ID = 7'b1101111;
    localparam int EN_A    = 1;
    localparam int EN_B    = 2;

    typedef logic [AW-1:0] addr_t;
    typedef logic [BW-1:0] byte_t;
    typedef logic [TIME_N-1:0][BW-1:0] time_t;

    typedef enum logic [1:0] {SEC_CTRL, SEC_TIME, SEC_STAT, SEC_VOID} sec_e;
    typedef enum logic [2:0] {PH_IDLE, PH_DEV, PH_ADDR, PH_WR, PH_RD, PH_HALT} phase_e;

    // Commands from the sequencer to the time path
    typedef struct packed {
        logic             load;
        logic             wr;
        logic             commit;
        logic             drop;
        logic             snap;
        logic [TIX_W-1:0] idx;
        byte_t            data;
    } tcmd_t;

    function automatic sec_e sec_of(addr_t a);
        if (a <= addr_t'(CTRL_HI))      return SEC_CTRL;
        else if (a <= addr_t'(TIME_HI)) return SEC_TIME;
        else if (a == addr_t'(STAT_AD)) return SEC_STAT;
        else                            return SEC_VOID;
    endfunction

    // Next pointer value, wrapping inside the group the transfer began in
    function automatic addr_t step(addr_t a, sec_e s);
        case (s)
            SEC_CTRL: return (a == addr_t'(CTRL_HI)) ? addr_t'(CTRL_LO) : a + addr_t'(1);
            SEC_TIME: return (a == addr_t'(TIME_HI)) ? addr_t'(TIME_LO) : a + addr_t'(1);
            SEC_STAT: return a;
            default:  return a + addr_t'(1);
        endcase
    endfunction

    function automatic logic [TIX_W-1:0] tix(addr_t a);
        return a[TIX_W-1:0] - TIX_W'(TIME_LO);
    endfunction
endpackage

// File: rtl/rtcr_timebase.sv
`timescale 1ns/1ps
module rtcr_timebase
    import rtcr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  tcmd_t            cmd_i,
    input  logic [TIX_W-1:0] rd_idx_i,
    output byte_t            rd_data_o,
    output logic [TW-1:0]    time_o
);
    time_t cnt, stage, held, snap;
    logic  dirty, pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            stage <= '0;
            held  <= '0;
            snap  <= '0;
            dirty <= 1'b0;
            pend  <= 1'b0;
        end else begin
            if (tick_i) begin
                if (pend) begin
                    cnt  <= held;
                    pend <= 1'b0;
                end else begin
                    cnt <= cnt + TW'(1);
                end
            end
            if (cmd_i.load) stage <= cnt;
            if (cmd_i.wr) begin
                stage[cmd_i.idx] <= cmd_i.data;
                dirty            <= 1'b1;
            end
            if (cmd_i.commit) begin
                if (dirty) begin
                    held <= stage;
                    pend <= 1'b1;
                end
                dirty <= 1'b0;
            end
            if (cmd_i.drop) dirty <= 1'b0;
            if (cmd_i.snap) snap <= cnt;
        end
    end

    assign rd_data_o = snap[rd_idx_i];
    assign time_o    = cnt;

    assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(cnt));
    assert_commit_land_R3: assert property (@(posedge clk) disable iff (rst)
        (tick_i && pend) |=> (cnt == $past(held)));
    assert_snap_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !cmd_i.snap |=> $stable(snap));
    assert_drop_noarm_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.drop && !pend) |=> !pend);
endmodule

// File: rtl/rtcr_seq.sv
`timescale 1ns/1ps
module rtcr_seq
    import rtcr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  logic  stop_i,
    input  logic  abort_i,
    input  logic  byte_vld_i,
    input  byte_t byte_i,
    input  logic  ack_i,
    input  logic  rd_req_i,
    input  logic  wr_ok_i,
    output logic  ack_o,
    output logic  halt_o,
    output addr_t ptr_o,
    output tcmd_t tcmd_o,
    output logic  ctrl_we_o,
    output logic  stat_we_o,
    output byte_t wdata_o,
    output logic  rd_fire_o
);
    phase_e phase;
    sec_e   op_sec;
    addr_t  ptr;
    logic   first, loaded, ack_q;
    logic   bus_evt, stat_over, wr_go, rd_go;

    always_comb begin
        bus_evt   = start_i | stop_i | abort_i;
        stat_over = (op_sec == SEC_STAT) && !first;
        wr_go     = (phase == PH_WR) && byte_vld_i && !stat_over && !bus_evt;
        rd_go     = (phase == PH_RD) && rd_req_i && !stat_over && !bus_evt;

        tcmd_o        = '0;
        tcmd_o.idx    = tix(ptr);
        tcmd_o.data   = byte_i;
        tcmd_o.load   = (phase == PH_WR) && ack_i && !loaded;
        tcmd_o.snap   = (phase == PH_RD) && ack_i && !loaded;
        tcmd_o.wr     = wr_go && (op_sec == SEC_TIME) && wr_ok_i;
        tcmd_o.commit = stop_i && !abort_i && (phase == PH_WR);
        tcmd_o.drop   = abort_i || (start_i && (phase == PH_WR));

        ctrl_we_o = wr_go && (op_sec == SEC_CTRL) && wr_ok_i;
        stat_we_o = wr_go && (op_sec == SEC_STAT);
        wdata_o   = byte_i;
        rd_fire_o = rd_go;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            op_sec <= SEC_CTRL;
            ptr    <= '0;
            first  <= 1'b0;
            loaded <= 1'b0;
            ack_q  <= 1'b0;
        end else if (abort_i) begin
            phase <= PH_IDLE;
        end else if (start_i) begin
            phase  <= PH_DEV;
            first  <= 1'b1;
            loaded <= 1'b0;
        end else if (stop_i) begin
            phase <= PH_IDLE;
        end else begin
            case (phase)
                PH_DEV: if (byte_vld_i) begin
                    if (byte_i[BW-1:1] == DEV_ID) begin
                        ack_q  <= 1'b1;
                        phase  <= byte_i[0] ? PH_RD : PH_ADDR;
                        op_sec <= sec_of(ptr);
                    end else begin
                        ack_q <= 1'b0;
                        phase <= PH_IDLE;
                    end
                end
                PH_ADDR: if (byte_vld_i) begin
                    if (byte_i[BW-1:AW] == '0) begin
                        ack_q  <= 1'b1;
                        ptr    <= byte_i[AW-1:0];
                        op_sec <= sec_of(byte_i[AW-1:0]);
                        phase  <= PH_WR;
                    end else begin
                        ack_q <= 1'b0;
                        phase <= PH_IDLE;
                    end
                end
                PH_WR: begin
                    if (ack_i) loaded <= 1'b1;
                    if (byte_vld_i) begin
                        if (wr_go) begin
                            ack_q <= 1'b1;
                            first <= 1'b0;
                            ptr   <= step(ptr, op_sec);
                        end else begin
                            ack_q <= 1'b0;
                            phase <= PH_HALT;
                        end
                    end
                end
                PH_RD: begin
                    if (ack_i) loaded <= 1'b1;
                    if (rd_req_i) begin
                        if (rd_go) begin
                            first <= 1'b0;
                            ptr   <= step(ptr, op_sec);
                        end else begin
                            phase <= PH_HALT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign ack_o  = ack_q;
    assign halt_o = (phase == PH_HALT);
    assign ptr_o  = ptr;

    assert_time_span_R8: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_WR || phase == PH_RD) && op_sec == SEC_TIME)
        |-> (ptr >= addr_t'(TIME_LO) && ptr <= addr_t'(TIME_HI)));
    assert_ctrl_span_R8: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_WR || phase == PH_RD) && op_sec == SEC_CTRL)
        |-> (ptr <= addr_t'(CTRL_HI)));
    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HALT && !start_i && !stop_i && !abort_i) |=> (phase == PH_HALT));
endmodule

// File: rtl/rtcr_top.sv
`timescale 1ns/1ps
module rtcr_top
    import rtcr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          abort_i,
    input  logic          byte_vld_i,
    input  logic [7:0]    byte_i,
    input  logic          ack_i,
    input  logic          rd_req_i,
    output logic          ack_o,
    output logic          halt_o,
    output logic [7:0]    tx_data_o,
    output logic [63:0]   time_o
);
    addr_t ptr;
    tcmd_t tcmd;
    logic  ctrl_we, stat_we, rd_fire, wr_ok;
    byte_t wdata, t_rd, rbyte, stat_q, tx_q;
    logic [CTRL_N-1:0][BW-1:0] ctrl_q;

    assign wr_ok = stat_q[EN_A] & stat_q[EN_B];

    rtcr_seq u_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i), .abort_i(abort_i),
        .byte_vld_i(byte_vld_i), .byte_i(byte_i), .ack_i(ack_i), .rd_req_i(rd_req_i),
        .wr_ok_i(wr_ok), .ack_o(ack_o), .halt_o(halt_o), .ptr_o(ptr), .tcmd_o(tcmd),
        .ctrl_we_o(ctrl_we), .stat_we_o(stat_we), .wdata_o(wdata), .rd_fire_o(rd_fire)
    );

    rtcr_timebase u_time (
        .clk(clk), .rst(rst), .tick_i(tick_i), .cmd_i(tcmd),
        .rd_idx_i(tix(ptr)), .rd_data_o(t_rd), .time_o(time_o)
    );

    always_comb begin
        case (sec_of(ptr))
            SEC_CTRL: rbyte = ctrl_q[ptr[CIW-1:0]];
            SEC_TIME: rbyte = t_rd;
            SEC_STAT: rbyte = stat_q;
            default:  rbyte = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            stat_q <= '0;
            tx_q   <= '0;
        end else begin
            if (ctrl_we) ctrl_q[ptr[CIW-1:0]] <= wdata;
            if (stat_we) stat_q <= wdata;
            if (rd_fire) tx_q <= rbyte;
        end
    end

    assign tx_data_o = tx_q;

    assert_ctrl_guard_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_ok |=> $stable(ctrl_q));
endmodule

// File: tb/sim_rtcr_top.sv
`timescale 1ns/1ps
module sim_rtcr_top;
    localparam int K_TICK = 0, K_START = 1, K_STOP = 2, K_ABORT = 3,
                   K_BYTE = 4, K_ACK = 5, K_RD = 6;
    localparam logic [7:0] SEL_W = 8'hDE, SEL_R = 8'hDF;

    logic clk = 1'b0, rst = 1'b1;
    logic tick_i = 0, start_i = 0, stop_i = 0, abort_i = 0;
    logic byte_vld_i = 0, ack_i = 0, rd_req_i = 0;
    logic [7:0] byte_i = '0;
    logic ack_o, halt_o;
    logic [7:0] tx_data_o;
    logic [63:0] time_o;

    int nchk = 0, nerr = 0;
    bit done = 0;
    logic [7:0] ctrl_m [2];
    logic [7:0] stat_m;
    logic [7:0] wbuf [16];
    logic [7:0] rbuf [16];

    always #2.5 clk = ~clk;

    rtcr_top u0 (
        .clk(clk), .rst(rst), .tick_i(tick_i), .start_i(start_i), .stop_i(stop_i),
        .abort_i(abort_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i), .ack_i(ack_i),
        .rd_req_i(rd_req_i), .ack_o(ack_o), .halt_o(halt_o), .tx_data_o(tx_data_o),
        .time_o(time_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ev(input int k, input logic [7:0] b = 8'h00);
        @(negedge clk);
        case (k)
            K_TICK:  tick_i = 1;
            K_START: start_i = 1;
            K_STOP:  stop_i = 1;
            K_ABORT: abort_i = 1;
            K_BYTE:  begin byte_vld_i = 1; byte_i = b; end
            K_ACK:   ack_i = 1;
            K_RD:    rd_req_i = 1;
            default: ;
        endcase
        @(negedge clk);
        {tick_i, start_i, stop_i, abort_i, byte_vld_i, ack_i, rd_req_i} = '0;
    endtask

    task automatic do_write(input logic [7:0] a, input int n);
        ev(K_START); ev(K_BYTE, SEL_W); ev(K_ACK); ev(K_BYTE, a); ev(K_ACK);
        for (int i = 0; i < n; i++) begin ev(K_BYTE, wbuf[i]); ev(K_ACK); end
        ev(K_STOP);
    endtask

    task automatic do_read(input logic [7:0] a, input int n, output logic [63:0] t);
        ev(K_START); ev(K_BYTE, SEL_W); ev(K_ACK); ev(K_BYTE, a); ev(K_ACK);
        ev(K_START); ev(K_BYTE, SEL_R);
        t = time_o;
        ev(K_ACK);
        for (int i = 0; i < n; i++) begin ev(K_RD); rbuf[i] = tx_data_o; end
        ev(K_STOP);
    endtask

    task automatic cur_read(output logic [63:0] t);
        ev(K_START); ev(K_BYTE, SEL_R);
        t = time_o;
        ev(K_ACK); ev(K_RD); rbuf[0] = tx_data_o;
        ev(K_STOP);
    endtask

    function automatic int grp(input int a);
        if (a <= 1) return 0;
        if (a <= 9) return 1;
        if (a == 10) return 2;
        return 3;
    endfunction

    function automatic int nxt(input int a, input int g);
        case (g)
            0: return (a == 1) ? 0 : a + 1;
            1: return (a == 9) ? 2 : a + 1;
            2: return a;
            default: return (a + 1) % 64;
        endcase
    endfunction

    function automatic logic [7:0] exp_byte(input int a, input logic [63:0] t);
        case (grp(a))
            0: return ctrl_m[a];
            1: return t[(a-2)*8 +: 8];
            2: return stat_m;
            default: return 8'h00;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [63:0] t, t2, v, e;
        int a, g, p;
        logic [7:0] prev;
        ctrl_m[0] = 0; ctrl_m[1] = 0; stat_m = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R12 reset state
        chk("R12 ack", ack_o, 0); chk("R12 halt", halt_o, 0);
        chk("R12 time", time_o, 0); chk("R12 tx", tx_data_o, 0);

        // R5 ticks advance the counter
        for (int i = 0; i < 5; i++) ev(K_TICK);
        chk("R5 five ticks", time_o, 5);

        // R10 writes ignored while enables clear
        wbuf[0] = 8'hAA; do_write(8'h00, 1);
        wbuf[0] = 8'h55; do_write(8'h02, 1);
        ev(K_TICK);
        chk("R10 time write blocked", time_o, 6);
        do_read(8'h00, 1, t);
        chk("R10 ctrl write blocked", rbuf[0], 8'h00);

        // R10 status write needs no enable
        wbuf[0] = 8'h06; do_write(8'h0A, 1); stat_m = 8'h06;
        do_read(8'h0A, 1, t);
        chk("R10 status write", rbuf[0], 8'h06);

        // R1 select decode
        ev(K_START); ev(K_BYTE, SEL_W);
        chk("R1 good select acked", ack_o, 1);
        ev(K_STOP);
        ev(K_START); ev(K_BYTE, 8'hA0);
        chk("R1 bad select nacked", ack_o, 0);
        ev(K_BYTE, 8'h00); ev(K_ACK); ev(K_BYTE, 8'h99); ev(K_ACK); ev(K_STOP);
        do_read(8'h00, 1, t);
        chk("R1 bytes after bad select ignored", rbuf[0], 8'h00);

        // R2 address window
        ev(K_START); ev(K_BYTE, SEL_W); ev(K_ACK); ev(K_BYTE, 8'h40);
        chk("R2 address 0x40 nacked", ack_o, 0);
        ev(K_STOP);
        ev(K_START); ev(K_BYTE, SEL_W); ev(K_ACK); ev(K_BYTE, 8'h3F);
        chk("R2 address 0x3F acked", ack_o, 1);
        ev(K_STOP);

        // R8 control page write wraps 0x01 -> 0x00
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; do_write(8'h01, 2);
        ctrl_m[1] = 8'h11; ctrl_m[0] = 8'h22;
        do_read(8'h00, 3, t);
        chk("R8 ctrl read 0", rbuf[0], 8'h22);
        chk("R8 ctrl read 1", rbuf[1], 8'h11);
        chk("R8 ctrl read wrap", rbuf[2], 8'h22);

        // R3 / R5 full time write with ticks inside the transfer
        v = 64'h0123_4567_89AB_CDEF;
        t = time_o;
        ev(K_START); ev(K_BYTE, SEL_W); ev(K_ACK); ev(K_BYTE, 8'h02); ev(K_ACK);
        ev(K_TICK);
        for (int i = 0; i < 8; i++) begin
            ev(K_BYTE, v[i*8 +: 8]); ev(K_ACK);
            if (i == 3) ev(K_TICK);
        end
        ev(K_STOP);
        chk("R5 count runs during write", time_o, t + 2);
        ev(K_TICK);
        chk("R3 commit on first tick", time_o, v);
        ev(K_TICK);
        chk("R3 counts on from committed", time_o, v + 1);

        // R6 single-byte write sweep over all time bytes
        for (int k = 0; k < 8; k++) begin
            t = time_o;
            wbuf[0] = 8'h10 + 8'(k);
            do_write(8'(2 + k), 1);
            chk("R3 no change before tick", time_o, t);
            ev(K_TICK);
            e = t; e[k*8 +: 8] = 8'h10 + 8'(k);
            chk("R6 single byte merge", time_o, e);
        end

        // R4 abort and repeated start discard staged data
        t = time_o;
        ev(K_START); ev(K_BYTE, SEL_W); ev(K_ACK); ev(K_BYTE, 8'h02); ev(K_ACK);
        ev(K_BYTE, 8'hFF); ev(K_ACK); ev(K_ABORT);
        ev(K_TICK);
        chk("R4 abort discards", time_o, t + 1);
        ev(K_START); ev(K_BYTE, SEL_W); ev(K_ACK); ev(K_BYTE, 8'h05); ev(K_ACK);
        ev(K_BYTE, 8'hEE); ev(K_ACK); ev(K_START); ev(K_STOP);
        ev(K_TICK);
        chk("R4 restart discards", time_o, t + 2);

        // R7 snapshot frozen during read
        ev(K_START); ev(K_BYTE, SEL_W); ev(K_ACK); ev(K_BYTE, 8'h02); ev(K_ACK);
        ev(K_START); ev(K_BYTE, SEL_R);
        t = time_o;
        ev(K_ACK); ev(K_TICK); ev(K_TICK);
        for (int i = 0; i < 8; i++) begin
            ev(K_RD);
            chk("R7 snapshot byte", tx_data_o, t[i*8 +: 8]);
        end
        ev(K_STOP);

        // R8 / R9 / R11 sequential read sweep from every start address
        for (int s = 0; s < 12; s++) begin
            a = (s == 11) ? 32 : s;
            do_read(8'(a), 9, t);
            g = grp(a); p = a; prev = 8'h00;
            for (int i = 0; i < 9; i++) begin
                if (g == 2 && i > 0) e = {56'h0, prev};
                else begin
                    e = {56'h0, exp_byte(p, t)};
                    prev = e[7:0];
                    p = nxt(p, g);
                end
                chk("R8 sequential read", rbuf[i], e);
            end
            cur_read(t2);
            chk("R11 current address read", rbuf[0], exp_byte(p, t2));
        end

        // R9 status write overrun
        ev(K_START); ev(K_BYTE, SEL_W); ev(K_ACK); ev(K_BYTE, 8'h0A); ev(K_ACK);
        ev(K_BYTE, 8'h06); ev(K_ACK);
        chk("R9 first status byte acked", ack_o, 1);
        ev(K_BYTE, 8'hFF);
        chk("R9 second status byte nacked", ack_o, 0);
        chk("R9 halted", halt_o, 1);
        ev(K_STOP);
        chk("R9 halt released by stop", halt_o, 0);
        do_read(8'h0A, 1, t);
        chk("R9 status kept first byte", rbuf[0], 8'h06);

        // R10 dropping one enable blocks control writes again
        wbuf[0] = 8'h02; do_write(8'h0A, 1); stat_m = 8'h02;
        wbuf[0] = 8'h5A; do_write(8'h00, 1);
        do_read(8'h00, 1, t);
        chk("R10 single enable insufficient", rbuf[0], ctrl_m[0]);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule